// File: doc/BRIEF.md
# Subroutine Call/Return Bus Sequencer

This block is the control unit of an 8-bit processor with a 16-bit address bus, cut down to two opcodes: the subroutine call (0x20) and the subroutine return (0x60). It moves one step per clock. In each step it drives an address, a write strobe and write data, and it samples the read data bus at the clock edge that closes the step. It holds the program counter, an 8-bit stack pointer and a single latch for the low target byte. The stack occupies address page 0x01.

The call stores its return address on the stack before it fetches the high target byte. That high byte therefore never needs a register of its own: it goes straight from the read bus into the program counter, next to the latched low byte. As a result the stored address points at the call's own last byte. The return corrects for this by reading that byte once more and discarding it, then adding one. An opcode other than the two handled ones stops the sequencer until reset.

Top module: `callret_seq`

## Requirements
- R1: While reset is active and in the cycle after it, the address equals the reset program counter, the write strobe is 0, the step is 0, and both the done pulse and the halt flag are 0.
- R2: A call (opcode 0x20 fetched at address P, stack pointer S) takes six steps, numbered 0 to 5. It reads P, reads P+1 (low target byte), reads 0x01:S with no write, writes at 0x01:S, writes at 0x01:(S-1), and reads P+2 (high target byte).
- R3: The call writes the high half of P+2 in step 3 and the low half of P+2 in step 4. The stored return value is the address of the call's third byte.
- R4: After a call, the next opcode fetch comes in the cycle after step 5, at {byte read in step 5, byte read in step 1}. The stack pointer ends at S-2.
- R5: A return (opcode 0x60 at P, stack pointer S) takes six steps. It reads P, reads P+1 (discarded), reads 0x01:S, reads 0x01:(S+1) as the low byte, reads 0x01:(S+2) as the high byte, and then reads the popped address Q with the data discarded. The next fetch is at Q+1 and the stack pointer ends at S+2.
- R6: The increment at the end of a return carries into the high byte: a popped 0x12FF resumes at 0x1300.
- R7: Every write lands in page 0x01. The stack pointer wraps modulo 256 in both directions: a push at 0x00 is followed by one at 0xFF, and a pop past 0xFF reads 0x00.
- R8: Nested calls, including a call whose target is itself a call, followed by the same number of returns, restore the program counter to the byte after the outer call and the stack pointer to its value before that call.
- R9: The step output counts 0 to 5 within each instruction, and the done pulse is high exactly in step 5.
- R10: A fetched opcode other than 0x20 or 0x60 sets the halt flag from the next cycle on. From then until reset the address stays at that opcode's address, no write occurs and the step stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| rd_data | input | 8 | Read data for the current step, sampled at the closing clock edge |
| addr | output | 16 | Bus address of the current step |
| wr_en | output | 1 | 1 when the current step writes |
| wr_data | output | 8 | Data for a write step |
| step | output | 3 | Step index within the current instruction, 0 to 5 |
| instr_done | output | 1 | High in the last step of an instruction |
| halted | output | 1 | Sticky flag set by an unhandled opcode |

## Verification
The bench runs a fixed program through a memory model and compares every bus step with a trace it computes from its own program counter and stack pointer. The program includes a lone call and return, a three-deep nest whose middle target is another call, a return whose popped address ends in 0xFF, and pops and pushes that cross the stack pointer boundary in both directions. The lone pair shows the ordering of the stack writes against the high-byte read. The nest shows whether the stack pointer and the program counter are restored. The 0xFF case shows whether the carry is dropped, and the boundary crossings show where wrap-around fails. A final illegal opcode shows that the sequencer freezes rather than going on to a later step.

// File: rtl/callret_pkg.sv
package callret_pkg;

    localparam int DW = 8;
    localparam int AW = 2 * DW;
    localparam int SW = 3;

    localparam logic [DW-1:0] OP_CALL = 8'h20;
    localparam logic [DW-1:0] OP_RET  = 8'h60;

    typedef enum logic [SW-1:0] {
        ST_FETCH = 3'd0,
        ST_OPND  = 3'd1,
        ST_STK   = 3'd2,
        ST_XA    = 3'd3,
        ST_XB    = 3'd4,
        ST_LAST  = 3'd5
    } step_e;

    typedef enum logic [1:0] {K_NONE, K_CALL, K_RET} kind_e;
    typedef enum logic      {A_PC, A_STACK}          asel_e;
    typedef enum logic      {W_PCH, W_PCL}           wsel_e;
    typedef enum logic [2:0] {PC_HOLD, PC_INC, PC_LD_LO, PC_LD_HI, PC_JUMP} pcop_e;
    typedef enum logic [1:0] {SP_HOLD, SP_DEC, SP_INC} spop_e;

    typedef struct packed {
        asel_e asel;
        logic  we;
        wsel_e wsel;
        pcop_e pc_op;
        spop_e sp_op;
        logic  adl_ld;
    } ctrl_t;

    localparam ctrl_t CTL_IDLE = '{asel: A_PC, we: 1'b0, wsel: W_PCH,
                                   pc_op: PC_HOLD, sp_op: SP_HOLD, adl_ld: 1'b0};

    function automatic kind_e op_kind(input logic [DW-1:0] op);
        if (op == OP_CALL) return K_CALL;
        if (op == OP_RET)  return K_RET;
        return K_NONE;
    endfunction

endpackage

// File: rtl/callret_ctrl.sv
module callret_ctrl
    import callret_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] rd_data,
    output ctrl_t         ctl,
    output step_e         step,
    output logic          done,
    output logic          halted
);

    step_e step_q, step_d;
    kind_e kind_q, kind_d;
    logic  halt_q, halt_d;

    always_comb begin
        ctl    = CTL_IDLE;
        step_d = step_q;
        kind_d = kind_q;
        halt_d = halt_q;
        done   = 1'b0;
        if (!halt_q) begin
            case (step_q)
                ST_FETCH: begin
                    kind_d = op_kind(rd_data);
                    if (kind_d == K_NONE) begin
                        halt_d = 1'b1;
                    end else begin
                        ctl.pc_op = PC_INC;
                        step_d    = ST_OPND;
                    end
                end
                ST_OPND: begin
                    if (kind_q == K_CALL) begin
                        ctl.pc_op  = PC_INC;
                        ctl.adl_ld = 1'b1;
                    end
                    step_d = ST_STK;
                end
                ST_STK: begin
                    ctl.asel = A_STACK;
                    if (kind_q == K_RET) ctl.sp_op = SP_INC;
                    step_d = ST_XA;
                end
                ST_XA: begin
                    ctl.asel = A_STACK;
                    if (kind_q == K_CALL) begin
                        ctl.we    = 1'b1;
                        ctl.wsel  = W_PCH;
                        ctl.sp_op = SP_DEC;
                    end else begin
                        ctl.pc_op = PC_LD_LO;
                        ctl.sp_op = SP_INC;
                    end
                    step_d = ST_XB;
                end
                ST_XB: begin
                    ctl.asel = A_STACK;
                    if (kind_q == K_CALL) begin
                        ctl.we    = 1'b1;
                        ctl.wsel  = W_PCL;
                        ctl.sp_op = SP_DEC;
                    end else begin
                        ctl.pc_op = PC_LD_HI;
                    end
                    step_d = ST_LAST;
                end
                ST_LAST: begin
                    done      = 1'b1;
                    ctl.pc_op = (kind_q == K_CALL) ? PC_JUMP : PC_INC;
                    step_d    = ST_FETCH;
                end
                default: step_d = ST_FETCH;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            step_q <= ST_FETCH;
            kind_q <= K_NONE;
            halt_q <= 1'b0;
        end else begin
            step_q <= step_d;
            kind_q <= kind_d;
            halt_q <= halt_d;
        end
    end

    assign step   = step_q;
    assign halted = halt_q;

endmodule

// File: rtl/callret_dp.sv
module callret_dp
    import callret_pkg::*;
#(
    parameter logic [AW-1:0] RESET_PC   = 16'h0200,
    parameter logic [DW-1:0] RESET_SP   = 8'hFD,
    parameter logic [DW-1:0] STACK_PAGE = 8'h01
) (
    input  logic          clk,
    input  logic          rst,
    input  ctrl_t         ctl,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] addr,
    output logic          wr_en,
    output logic [DW-1:0] wr_data
);

    logic [AW-1:0] pc_q;
    logic [DW-1:0] sp_q;
    logic [DW-1:0] adl_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q  <= RESET_PC;
            sp_q  <= RESET_SP;
            adl_q <= '0;
        end else begin
            case (ctl.pc_op)
                PC_INC:   pc_q          <= pc_q + AW'(1);
                PC_LD_LO: pc_q[DW-1:0]  <= rd_data;
                PC_LD_HI: pc_q[AW-1:DW] <= rd_data;
                PC_JUMP:  pc_q          <= {rd_data, adl_q};
                default:  ;
            endcase
            case (ctl.sp_op)
                SP_DEC:  sp_q <= sp_q - DW'(1);
                SP_INC:  sp_q <= sp_q + DW'(1);
                default: ;
            endcase
            if (ctl.adl_ld) adl_q <= rd_data;
        end
    end

    assign addr    = (ctl.asel == A_STACK) ? {STACK_PAGE, sp_q} : pc_q;
    assign wr_en   = ctl.we;
    assign wr_data = (ctl.wsel == W_PCH) ? pc_q[AW-1:DW] : pc_q[DW-1:0];

endmodule

// File: rtl/callret_seq.sv
module callret_seq
    import callret_pkg::*;
#(
    parameter logic [AW-1:0] RESET_PC   = 16'h0200,
    parameter logic [DW-1:0] RESET_SP   = 8'hFD,
    parameter logic [DW-1:0] STACK_PAGE = 8'h01
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] addr,
    output logic          wr_en,
    output logic [DW-1:0] wr_data,
    output logic [SW-1:0] step,
    output logic          instr_done,
    output logic          halted
);

    ctrl_t ctl;
    step_e step_w;

    callret_ctrl u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .rd_data (rd_data),
        .ctl     (ctl),
        .step    (step_w),
        .done    (instr_done),
        .halted  (halted)
    );

    callret_dp #(
        .RESET_PC   (RESET_PC),
        .RESET_SP   (RESET_SP),
        .STACK_PAGE (STACK_PAGE)
    ) u_dp (
        .clk     (clk),
        .rst     (rst),
        .ctl     (ctl),
        .rd_data (rd_data),
        .addr    (addr),
        .wr_en   (wr_en),
        .wr_data (wr_data)
    );

    assign step = step_w;

endmodule

// File: rtl/callret_chk.sv
module callret_chk
    import callret_pkg::*;
#(
    parameter logic [DW-1:0] PAGE = 8'h01
) (
    input logic          clk,
    input logic          rst,
    input logic [AW-1:0] addr,
    input logic          wr_en,
    input logic [SW-1:0] step,
    input logic          instr_done,
    input logic          halted
);

    logic armed;
    always_ff @(posedge clk) armed <= !rst;

    assert_stack_page_R7: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> addr[AW-1:DW] == PAGE)
        else $error("write outside stack page");

    assert_push_descends_R7: assert property (@(posedge clk) disable iff (rst)
        armed && wr_en && $past(wr_en) |-> addr[DW-1:0] == $past(addr[DW-1:0]) - 8'd1)
        else $error("second push not one below first");

    assert_writes_then_last_R2: assert property (@(posedge clk) disable iff (rst)
        armed && !wr_en && $past(wr_en) |-> instr_done)
        else $error("step after pushes is not the final step");

    assert_step_advance_R9: assert property (@(posedge clk) disable iff (rst)
        armed && step != 3'd0 |-> step == $past(step) + 3'd1)
        else $error("step skipped");

    assert_done_then_fetch_R9: assert property (@(posedge clk) disable iff (rst)
        instr_done |=> step == 3'd0 && !wr_en)
        else $error("no fetch after done");

    assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (rst)
        halted |=> halted && !wr_en && $stable(addr) && step == 3'd0)
        else $error("halt state left or bus moved");

endmodule

bind callret_seq callret_chk #(.PAGE(STACK_PAGE)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .addr       (addr),
    .wr_en      (wr_en),
    .step       (step),
    .instr_done (instr_done),
    .halted     (halted)
);

// File: tb/test_callret_seq.sv
module test_callret_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [7:0]  rd_data = 8'h00;
    logic [15:0] addr;
    logic        wr_en;
    logic [7:0]  wr_data;
    logic [2:0]  step;
    logic        instr_done;
    logic        halted;

    always #5 clk = ~clk;

    callret_seq i_callret_seq (
        .clk        (clk),
        .rst        (rst),
        .rd_data    (rd_data),
        .addr       (addr),
        .wr_en      (wr_en),
        .wr_data    (wr_data),
        .step       (step),
        .instr_done (instr_done),
        .halted     (halted)
    );

    logic [7:0] mem [logic [15:0]];
    int checks = 0;
    int failures = 0;
    logic [15:0] m_pc;
    logic [7:0]  m_sp;

    function automatic logic [7:0] rd(input logic [15:0] a);
        return mem.exists(a) ? mem[a] : 8'hEA;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one bus step: compare outputs mid-cycle, then act as the memory
    task automatic bus_cycle(input string req, input logic [15:0] ea, input logic ewe,
                             input logic [7:0] ewd, input logic [2:0] est, input logic edone);
        @(negedge clk);
        check(addr === ea, req, "addr", {16'h0, addr}, {16'h0, ea});
        check(wr_en === ewe, req, "wr_en", {31'h0, wr_en}, {31'h0, ewe});
        if (ewe) check(wr_data === ewd, req, "wr_data", {24'h0, wr_data}, {24'h0, ewd});
        check(step === est && instr_done === edone, req, "step/done (R9)",
              {28'h0, step, instr_done}, {28'h0, est, edone});
        if (wr_en === 1'b1) mem[addr] = wr_data;
        rd_data = rd(addr);
    endtask

    // expected trace from the requirements: R2..R5
    task automatic run_instr(input string req);
        logic [7:0]  op;
        logic [15:0] ret;
        logic [15:0] pop;
        op = rd(m_pc);
        if (op == 8'h20) begin
            ret = m_pc + 16'd2;
            bus_cycle(req, m_pc, 1'b0, 8'h00, 3'd0, 1'b0);
            bus_cycle(req, m_pc + 16'd1, 1'b0, 8'h00, 3'd1, 1'b0);
            bus_cycle(req, {8'h01, m_sp}, 1'b0, 8'h00, 3'd2, 1'b0);
            bus_cycle(req, {8'h01, m_sp}, 1'b1, ret[15:8], 3'd3, 1'b0);
            bus_cycle(req, {8'h01, m_sp - 8'd1}, 1'b1, ret[7:0], 3'd4, 1'b0);
            bus_cycle(req, m_pc + 16'd2, 1'b0, 8'h00, 3'd5, 1'b1);
            m_pc = {rd(m_pc + 16'd2), rd(m_pc + 16'd1)};
            m_sp = m_sp - 8'd2;
        end else if (op == 8'h60) begin
            pop = {rd({8'h01, m_sp + 8'd2}), rd({8'h01, m_sp + 8'd1})};
            bus_cycle(req, m_pc, 1'b0, 8'h00, 3'd0, 1'b0);
            bus_cycle(req, m_pc + 16'd1, 1'b0, 8'h00, 3'd1, 1'b0);
            bus_cycle(req, {8'h01, m_sp}, 1'b0, 8'h00, 3'd2, 1'b0);
            bus_cycle(req, {8'h01, m_sp + 8'd1}, 1'b0, 8'h00, 3'd3, 1'b0);
            bus_cycle(req, {8'h01, m_sp + 8'd2}, 1'b0, 8'h00, 3'd4, 1'b0);
            bus_cycle(req, pop, 1'b0, 8'h00, 3'd5, 1'b1);
            m_pc = pop + 16'd1;
            m_sp = m_sp + 8'd2;
        end else begin
            check(1'b0, req, "bench opcode", {24'h0, op}, 32'h20);
        end
    endtask

    task automatic do_reset_R1();
        rst = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        check(addr === 16'h0200 && wr_en === 1'b0, "R1", "reset bus",
              {15'h0, wr_en, addr}, {16'h0, 16'h0200});
        check(step === 3'd0 && instr_done === 1'b0 && halted === 1'b0, "R1", "reset flags",
              {27'h0, step, instr_done, halted}, 32'h0);
        rst = 1'b0;
        #1;
        check(addr === 16'h0200 && wr_en === 1'b0 && step === 3'd0 && halted === 1'b0,
              "R1", "after reset", {15'h0, wr_en, addr}, {16'h0, 16'h0200});
        m_pc = 16'h0200;
        m_sp = 8'hFD;
    endtask

    task automatic load_program();
        mem[16'h0200] = 8'h20; mem[16'h0201] = 8'h34; mem[16'h0202] = 8'h12;
        mem[16'h1234] = 8'h60;
        mem[16'h0203] = 8'h20; mem[16'h0204] = 8'hFD; mem[16'h0205] = 8'h12;
        mem[16'h12FD] = 8'h20; mem[16'h12FE] = 8'h00; mem[16'h12FF] = 8'h14;
        mem[16'h1400] = 8'h20; mem[16'h1401] = 8'h00; mem[16'h1402] = 8'h15;
        mem[16'h1500] = 8'h60;
        mem[16'h1403] = 8'h60;
        mem[16'h1300] = 8'h60;
        mem[16'h0206] = 8'h60;
        mem[16'h01FE] = 8'h0F; mem[16'h01FF] = 8'h03;
        mem[16'h0310] = 8'h60;
        mem[16'h0100] = 8'h1F; mem[16'h0101] = 8'h04;
        mem[16'h0420] = 8'h20; mem[16'h0421] = 8'h00; mem[16'h0422] = 8'h05;
        mem[16'h0423] = 8'hFF;
        mem[16'h0500] = 8'h20; mem[16'h0501] = 8'h00; mem[16'h0502] = 8'h06;
        mem[16'h0503] = 8'h60;
        mem[16'h0600] = 8'h60;
    endtask

    task automatic t_single_pair();
        run_instr("R2");
        check(rd(16'h01FD) === 8'h02 && rd(16'h01FC) === 8'h02, "R3", "stored return",
              {16'h0, rd(16'h01FD), rd(16'h01FC)}, 32'h0202);
        check(m_pc === 16'h1234, "R4", "bench target", {16'h0, m_pc}, 32'h1234);
        run_instr("R5");
    endtask

    task automatic t_nested();
        run_instr("R8");   // call 12FD, itself a call
        run_instr("R8");   // call 1400
        run_instr("R8");   // call 1500
        run_instr("R8");   // back to 1403
        run_instr("R6");   // pops 12FF, fetch must follow at 1300
        run_instr("R8");   // pops 0205, resumes at 0206 with SP restored
        check(m_pc === 16'h0206 && m_sp === 8'hFD, "R8", "restored state",
              {8'h0, m_sp, m_pc}, {8'h0, 8'hFD, 16'h0206});
    endtask

    task automatic t_wrap();
        run_instr("R7");   // pops FE,FF
        run_instr("R7");   // pops 00,01 after wrap
        run_instr("R7");   // pushes at 01,00
        run_instr("R7");   // pushes at FF,FE after wrap
        run_instr("R7");
        run_instr("R7");
        check(m_pc === 16'h0423, "R7", "end point", {16'h0, m_pc}, 32'h0423);
    endtask

    task automatic t_illegal();
        bus_cycle("R10", 16'h0423, 1'b0, 8'h00, 3'd0, 1'b0);
        for (int k = 0; k < 4; k++) begin
            bus_cycle("R10", 16'h0423, 1'b0, 8'h00, 3'd0, 1'b0);
            check(halted === 1'b1, "R10", "halt flag", {31'h0, halted}, 32'h1);
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL R9 watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        load_program();
        do_reset_R1();
        t_single_pair();
        t_nested();
        t_wrap();
        t_illegal();
        do_reset_R1();
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule